// File: doc/BRIEF.md
# Ring-Oscillator Entropy Collector

This block turns a vector of free-running oscillator bits into 32-bit entropy words. The oscillators arrive as an input vector, so the block stays synthesizable and a testbench can drive them. A timer fires once every sample interval. At each firing the whole oscillator vector is folded into one bit by XOR. The first and second folded bits are combined by XOR into one entropy bit, the third and fourth into the next, and so on. Each entropy bit enters the low end of a shift register. The oldest bit falls off the top, and collection never pauses.

Software reads through a small read port with two registers. The status register shows whether a fresh word is available. The data register returns the current word, and reading it withdraws the ready indication. The indication returns only once a full word's worth of new bits has been shifted in since that read.

Top module: `entropy_harvester`

## Requirements
- R1: After synchronous reset the entropy word is zero, the fresh-bit count is zero, the ready flag is clear and `rd_data` is zero.
- R2: The oscillator vector is sampled on the SAMPLE_INTERVAL-th rising edge after reset is released, then on every SAMPLE_INTERVAL-th edge after that. Each sample is the XOR of all NUM_OSC oscillator bits.
- R3: Samples are paired without overlap (first with second, third with fourth, and so on). Each pair yields one entropy bit equal to the XOR of its two samples.
- R4: An entropy bit enters bit 0 of the word on the edge after the second sample of its pair. All older bits move up one position and bit WORD_W-1 is discarded. The word is unchanged on every other edge.
- R5: Address 0 is status: bit 0 is the ready flag and all other bits read zero. Ready is set exactly when WORD_W entropy bits have entered since reset or since the last data read. The count saturates there.
- R6: A read of address 1 returns the word as it stood at the read edge and clears the fresh-bit count. If an entropy bit enters on that same edge, it counts as the first fresh bit.
- R7: A status read leaves the ready flag and the fresh-bit count untouched.
- R8: Collection continues while ready is set, so the word keeps changing until it is read.
- R9: Reads of addresses other than 0 and 1 return zero, and `rd_data` is zero in any cycle that follows an edge without a read.
- R10: Read data is registered and appears on the cycle after the edge that sampled `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | NUM_OSC | Free-running oscillator states |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Register select: 0 status, 1 data |
| rd_data | output | WORD_W | Registered read result |

## Verification
The hardest case to reach is a ready flag that stays low because the fresh-bit count is one short of a full word after a data read. The same goes for a count that restarts at one because a data read lands on the very edge a bit enters. The bench keeps a cycle-accurate reference of the sampling schedule and uses it to place status reads on the exact cycle the count reaches WORD_W-1 and WORD_W. It also places a data read on the shift edge itself. Constant oscillator patterns whose XOR is known (all zero, all one, a single set bit) make the word predictable without the model. Random patterns cover the general fold and pairing.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
  localparam int unsigned REG_STATUS_IDX = 0;
  localparam int unsigned REG_DATA_IDX   = 1;
endpackage

// File: rtl/entropy_sample_timer.sv
module entropy_sample_timer #(
  parameter int unsigned INTERVAL = 4096
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/entropy_pair_folder.sv
module entropy_pair_folder #(
  parameter int unsigned NUM_OSC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic [NUM_OSC-1:0] osc_i,
  output logic               bit_vld_o,
  output logic               bit_o
);
  logic fold;
  logic half_bit;
  logic have_half;

  // Fold the whole oscillator vector into one bit.
  assign fold = ^osc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_bit  <= 1'b0;
      have_half <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (tick_i) begin
        if (!have_half) begin
          half_bit  <= fold;
          have_half <= 1'b1;
        end else begin
          bit_o     <= half_bit ^ fold;
          bit_vld_o <= 1'b1;
          have_half <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/entropy_word_shifter.sv
module entropy_word_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bit_vld_i,
  input  logic                         bit_i,
  input  logic                         consume_i,
  output logic [WORD_W-1:0]            word_o,
  output logic [$clog2(WORD_W+1)-1:0]  fill_o,
  output logic                         ready_o
);
  localparam int unsigned FW = $clog2(WORD_W + 1);
  localparam logic [FW-1:0] FULL = FW'(WORD_W);

  assign ready_o = (fill_o == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
    end else if (bit_vld_i) begin
      word_o <= {word_o[WORD_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_o <= '0;
    end else if (consume_i) begin
      fill_o <= bit_vld_i ? FW'(1) : '0;
    end else if (bit_vld_i && !ready_o) begin
      fill_o <= fill_o + 1'b1;
    end
  end
endmodule

// File: rtl/entropy_harvester.sv
module entropy_harvester #(
  parameter int unsigned NUM_OSC         = 32,
  parameter int unsigned SAMPLE_INTERVAL = 4096,
  parameter int unsigned WORD_W          = 32,
  parameter int unsigned ADDR_W          = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OSC-1:0] osc_i,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data
);
  import entropy_pkg::*;

  localparam int unsigned FW = $clog2(WORD_W + 1);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS_IDX);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA_IDX);

  logic              tick;
  logic              ebit_vld;
  logic              ebit;
  logic              consume;
  logic [WORD_W-1:0] word;
  logic [FW-1:0]     fill;
  logic              ready;

  assign consume = rd_en && (rd_addr == A_DATA);

  entropy_sample_timer #(.INTERVAL(SAMPLE_INTERVAL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  entropy_pair_folder #(.NUM_OSC(NUM_OSC)) u_folder (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .osc_i     (osc_i),
    .bit_vld_o (ebit_vld),
    .bit_o     (ebit)
  );

  entropy_word_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .bit_vld_i (ebit_vld),
    .bit_i     (ebit),
    .consume_i (consume),
    .word_o    (word),
    .fill_o    (fill),
    .ready_o   (ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (!rd_en) begin
      rd_data <= '0;
    end else if (rd_addr == A_DATA) begin
      rd_data <= word;
    end else if (rd_addr == A_STATUS) begin
      rd_data <= {{(WORD_W-1){1'b0}}, ready};
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/entropy_harvester_chk.sv
module entropy_harvester_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           rd_addr,
  input logic [WORD_W-1:0]           rd_data,
  input logic                        tick,
  input logic                        ebit_vld,
  input logic [WORD_W-1:0]           word,
  input logic [$clog2(WORD_W+1)-1:0] fill,
  input logic                        ready
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(1);

  assert_pair_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
    ebit_vld |-> $past(tick));

  assert_shift_up_R4: assert property (@(posedge clk) disable iff (rst)
    ebit_vld |=> (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));

  assert_hold_word_R4: assert property (@(posedge clk) disable iff (rst)
    !ebit_vld |=> $stable(word));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= WORD_W);

  assert_status_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_STATUS) |=> (rd_data[WORD_W-1:1] == '0));

  assert_consume_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_DATA) |=> !ready);

  assert_status_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_STATUS && ready) |=> ready);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

bind entropy_harvester entropy_harvester_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .tick     (tick),
  .ebit_vld (ebit_vld),
  .word     (word),
  .fill     (fill),
  .ready    (ready)
);

// File: tb/test_entropy_harvester.sv
`timescale 1ns/1ps
module test_entropy_harvester;
  localparam int unsigned NOSC = 8;
  localparam int unsigned IVL  = 4;
  localparam int unsigned WW   = 32;
  localparam int unsigned AW   = 2;

  typedef struct {
    logic [WW-1:0] exp;
    string         tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NOSC-1:0] osc = '0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [WW-1:0]   rd_data;

  int checks = 0;
  int fails  = 0;
  int osc_mode = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  entropy_harvester #(.NUM_OSC(NOSC), .SAMPLE_INTERVAL(IVL), .WORD_W(WW), .ADDR_W(AW))
    i_entropy_harvester (
      .clk(clk), .rst(rst), .osc_i(osc), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  // Reference schedule built from R2..R6.
  int            m_cnt;
  logic          m_have, m_first, m_pend, m_pbit;
  logic [WW-1:0] m_word;
  int            m_fill;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_have <= 0; m_first <= 0; m_pend <= 0; m_pbit <= 0;
      m_word <= '0; m_fill <= 0;
    end else begin
      m_pend <= 1'b0;
      if (m_cnt == IVL - 1) begin
        m_cnt <= 0;
        if (!m_have) begin
          m_first <= ^osc; m_have <= 1'b1;
        end else begin
          m_pbit <= m_first ^ (^osc); m_pend <= 1'b1; m_have <= 1'b0;
        end
      end else begin
        m_cnt <= m_cnt + 1;
      end
      if (m_pend) m_word <= {m_word[WW-2:0], m_pbit};
      if (rd_en && rd_addr == AW'(1)) m_fill <= m_pend ? 1 : 0;
      else if (m_pend && m_fill < WW) m_fill <= m_fill + 1;
    end
  end

  // Oscillator stimulus, changed away from the clock edge.
  always @(negedge clk) begin
    case (osc_mode)
      1: osc <= '0;
      2: osc <= '1;
      3: osc <= NOSC'(1);
      default: osc <= NOSC'($urandom);
    endcase
  end

  // Monitor: one result per read, the cycle after (R10).
  logic mon_vld = 1'b0;
  always @(posedge clk) mon_vld <= rd_en;
  always @(negedge clk) begin
    if (mon_vld) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read result act=%h exp=<none>", "R10", rd_data);
      end else begin
        it = sb.pop_front();
        if (rd_data !== it.exp) begin
          fails++;
          $display("FAIL %s: act=%h exp=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input string tag, input bit use_lit = 0,
                         input logic [WW-1:0] lit = '0);
    item_t it;
    @(negedge clk);
    #0.1;
    if (use_lit) it.exp = lit;
    else if (a == AW'(1)) it.exp = m_word;
    else if (a == AW'(0)) it.exp = {{(WW-1){1'b0}}, (m_fill == WW)};
    else it.exp = '0;
    it.tag = tag;
    sb.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    #0.2;
    checks++;
    if (rd_data !== '0) begin
      fails++;
      $display("FAIL %s: idle act=%h exp=%h", tag, rd_data, {WW{1'b0}});
    end
  endtask

  task automatic wait_fill(input int n);
    while (m_fill != n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    do_read(AW'(0), "R1 status after reset", 1, '0);
    do_read(AW'(1), "R1 data after reset", 1, '0);
    check_idle("R9 idle after read");
    // R2/R3: all-ones on even count folds to 0, word stays zero
    osc_mode = 2;
    repeat (2 * IVL * 40) @(negedge clk);
    do_read(AW'(1), "R3 all-ones word", 1, '0);
    // single set bit: each sample 1, pairs XOR to 0
    osc_mode = 3;
    repeat (2 * IVL * 40) @(negedge clk);
    do_read(AW'(1), "R2 single-bit word", 1, '0);
    // random stimulus
    osc_mode = 0;
    wait_fill(WW);
    do_read(AW'(0), "R5 ready set");
    do_read(AW'(0), "R7 status read keeps ready");
    do_read(AW'(1), "R4 data random");
    do_read(AW'(0), "R6 ready cleared");
    wait_fill(WW - 1);
    do_read(AW'(0), "R5 one short of full");
    wait_fill(WW);
    do_read(AW'(0), "R5 full again");
    repeat (2 * IVL * 10) @(negedge clk);
    do_read(AW'(1), "R8 word after continued collection");
    do_read(AW'(2), "R9 unused address 2");
    do_read(AW'(3), "R9 unused address 3");
    check_idle("R9 idle zero");
    // R6: data read on the edge a bit enters
    while (!(m_cnt == IVL - 1 && m_have)) @(negedge clk);
    @(negedge clk);
    #0.1;
    begin
      item_t it;
      it.exp = m_word; it.tag = "R6 read on shift edge";
      sb.push_back(it);
      rd_en = 1'b1; rd_addr = AW'(1);
      @(negedge clk);
      rd_en = 1'b0; rd_addr = '0;
    end
    wait_fill(WW - 1);
    do_read(AW'(0), "R6 same-edge bit counted");
    wait_fill(WW);
    do_read(AW'(0), "R6 ready after restart");
    do_read(AW'(1), "R4 final data");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10: pending=%0d exp=0", sb.size());
    end
    finish_run();
  end
endmodule